// File: doc/BRIEF.md
# Add-with-carry execute unit

This unit runs one decoded add-with-extend operation at a time. It adds a source operand, a destination operand and the stored carry flag, at byte, word or long size, and writes the sum back to the destination. Each operand can be an immediate (source only), a view of one of eight 32-bit general registers, a memory operand addressed by a register, or a memory operand whose address register steps down by the operand size after the access. The unit then updates the H, N, Z, V and C flags. Chained additions of this kind are how multi-precision sums are built. For that reason Z only clears on a nonzero partial result and never sets.

Decode logic places the operation on the inputs and pulses `start`. The unit sequences any memory reads, computes the sum, writes it back and post-decrements any address registers, then raises `done` for one cycle. Two ports stand in for the writeback of other instructions: a register preload port and a flag preload port, both accepted only while the unit is idle. A combinational debug port reads any register. Memory is byte-wide and big-endian. Read data is returned one cycle after the read strobe.

Top module: `addx_unit`

## Requirements
- R1: The result is destination + source + C, truncated to the operation size (`op_size` 0 = byte, 1 = word, 2 or 3 = long). Mode codes are 0 immediate, 1 register, 2 indirect, 3 post-decrement. Destination mode 0 acts as register mode. An immediate source uses the low bits of `imm` at the operation size.
- R2: A selector is `{view, index}`, with the view in the top bit. For a byte, view 0 is bits 7:0 and view 1 is bits 15:8. A byte write changes only that byte of the register.
- R3: For a word, view 0 is bits 15:0 and view 1 is bits 31:16. A word write leaves the other half unchanged. A long operation uses and writes all 32 bits.
- R4: N is the result's top bit at the operation size. C is the carry out of that bit. V is set when two operands with the same sign give a result of the other sign. H is the carry out of bit 3, 11 or 27 for byte, word or long.
- R5: After an operation, Z = old Z AND (result == 0). Z never goes from 0 to 1 through an operation.
- R6: For an indirect operand, the low `ADDR_W` bits of the address register give the address of the most significant byte. Later bytes are at ascending addresses. A memory destination is written back at the addresses it was read from. The address register is unchanged afterwards.
- R7: A post-decrement operand is accessed at the register's value, and the register is then reduced by 1, 2 or 4 for byte, word or long.
- R8: When both operands use post-decrement, each address register is reduced by the operand size in the same operation.
- R9: Registers not written by the operation keep their values.
- R10: `start` is accepted only while `busy` is low. A `start` while busy is ignored. `done` is high for exactly one cycle per operation.
- R11: After reset, all registers and all flags read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the operation on the op inputs |
| op_size | input | 2 | 0 byte, 1 word, 2/3 long |
| src_mode | input | 2 | Source addressing mode |
| dst_mode | input | 2 | Destination addressing mode |
| src_sel | input | IDX_W+1 | Source selector {view, index} |
| dst_sel | input | IDX_W+1 | Destination selector {view, index} |
| imm | input | 32 | Immediate source value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after `mem_rd` |
| reg_load | input | 1 | Preload a register (idle only) |
| reg_load_idx | input | IDX_W | Register to preload |
| reg_load_data | input | 32 | Preload value |
| ccr_load | input | 1 | Preload flags (idle only) |
| ccr_in | input | 5 | Flags {H,N,Z,V,C} |
| dbg_sel | input | IDX_W | Register to read on the debug port |
| dbg_data | output | 32 | Selected register value |
| flag_h | output | 1 | Half carry |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry |

## Verification
The hardest case to reach is an operation with both operands in memory using post-decrement. It must read two big-endian values, write the sum back byte by byte and step two address registers one after the other. The stimulus reaches it by preloading two distinct address registers and a known memory image, then checking the whole memory image and every register against a bench model. A second start pulse is injected in the middle of a long memory-to-memory operation to show it has no effect. Carry-in and the sticky Z flag come from earlier operations or from the flag preload port, so carry chains are built up across consecutive operations.

// File: rtl/addx_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the add-with-carry execute unit.
// Assumes 32-bit general registers and size codes 0 byte, 1 word, 2/3 long.
package addx_pkg;
    localparam int REG_W = 32;

    typedef enum logic [1:0] {AM_IMM = 2'd0, AM_REG = 2'd1, AM_IND = 2'd2, AM_PDEC = 2'd3} amode_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SRD, ST_SCAP, ST_DRD, ST_DCAP, ST_EXEC, ST_WR, ST_USRC, ST_UDST, ST_FIN
    } xstate_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    // Mask of the bits that belong to an operand of the given size.
    function automatic logic [REG_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Index of the last byte of a memory operand.
    function automatic logic [1:0] last_byte(input logic [1:0] sz);
        case (sz)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    // Amount an address register steps down by.
    function automatic logic [REG_W-1:0] step_of(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'd1;
            2'd1:    return 32'd2;
            default: return 32'd4;
        endcase
    endfunction

    // Read a sub-register view, zero extended.
    function automatic logic [REG_W-1:0] view_get(input logic [REG_W-1:0] r, input logic hi,
                                                  input logic [1:0] sz);
        case (sz)
            2'd0:    return hi ? {24'd0, r[15:8]} : {24'd0, r[7:0]};
            2'd1:    return hi ? {16'd0, r[31:16]} : {16'd0, r[15:0]};
            default: return r;
        endcase
    endfunction

    // Byte enables of a sub-register view.
    function automatic logic [3:0] view_be(input logic hi, input logic [1:0] sz);
        case (sz)
            2'd0:    return hi ? 4'b0010 : 4'b0001;
            2'd1:    return hi ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // Place a value into the lanes of a sub-register view.
    function automatic logic [REG_W-1:0] view_put(input logic [REG_W-1:0] v, input logic hi,
                                                  input logic [1:0] sz);
        case (sz)
            2'd0:    return hi ? {16'd0, v[7:0], 8'd0} : {24'd0, v[7:0]};
            2'd1:    return hi ? {v[15:0], 16'd0} : {16'd0, v[15:0]};
            default: return v;
        endcase
    endfunction
endpackage

// File: rtl/addx_alu.sv
`timescale 1ns/1ps
// Size-aware adder with carry-in and flag generation.
// Assumes operands may carry junk above the operation size; they are masked here.
module addx_alu
    import addx_pkg::*;
(
    input  logic [REG_W-1:0] a,
    input  logic [REG_W-1:0] b,
    input  logic             cin,
    input  logic [1:0]       sz,
    input  logic             z_in,
    output logic [REG_W-1:0] sum,
    output flags_t           fl
);
    logic [REG_W-1:0] a_m, b_m;
    logic [REG_W:0]   full;
    logic [4:0]       h8;
    logic [12:0]      h16;
    logic [28:0]      h32;
    int unsigned      msb;

    // Add the masked operands and derive every flag at the selected size.
    always_comb begin
        a_m  = a & size_mask(sz);
        b_m  = b & size_mask(sz);
        full = {1'b0, a_m} + {1'b0, b_m} + {{REG_W{1'b0}}, cin};
        h8   = {1'b0, a_m[3:0]}  + {1'b0, b_m[3:0]}  + {4'd0, cin};
        h16  = {1'b0, a_m[11:0]} + {1'b0, b_m[11:0]} + {12'd0, cin};
        h32  = {1'b0, a_m[27:0]} + {1'b0, b_m[27:0]} + {28'd0, cin};
        sum  = full[REG_W-1:0] & size_mask(sz);
        case (sz)
            2'd0: begin msb = 7;  fl.c = full[8];  fl.h = h8[4];   end
            2'd1: begin msb = 15; fl.c = full[16]; fl.h = h16[12]; end
            default: begin msb = 31; fl.c = full[32]; fl.h = h32[28]; end
        endcase
        fl.n = sum[msb];
        fl.v = (a_m[msb] == b_m[msb]) && (sum[msb] != a_m[msb]);
        fl.z = z_in && (sum == '0);
    end
endmodule

// File: rtl/addx_regfile.sv
`timescale 1ns/1ps
// General register file with one byte-enabled write port and all registers readable.
// Assumes the caller arbitrates so that at most one write happens per cycle.
module addx_regfile #(
    parameter  int NREGS = 8,
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [3:0]             wr_be,
    input  logic [31:0]            wr_data,
    output logic [NREGS-1:0][31:0] regs_o
);
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        for (genvar k = 0; k < 4; k++) begin : g_lane
            // Write one byte lane of one register when addressed and enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_o[i][8*k +: 8] <= 8'd0;
                else if (wr_en && wr_be[k] && (wr_idx == IDX_W'(i)))
                    regs_o[i][8*k +: 8] <= wr_data[8*k +: 8];
            end

            // R2/R3: a lane outside the write enables keeps its value.
            a_r2_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (wr_idx == IDX_W'(i)) && !wr_be[k]) |=> $stable(regs_o[i][8*k +: 8]));
        end

        // R9: a register not addressed by the write port is unchanged.
        a_r9_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_idx == IDX_W'(i))) |=> $stable(regs_o[i]));
    end
endmodule

// File: rtl/addx_unit.sv
`timescale 1ns/1ps
// Add-with-carry execute unit: operand fetch, add, writeback, post-decrement.
// Assumes aligned memory operands and a memory that returns read data one cycle
// after the strobe; preloads are honoured only while idle.
module addx_unit
    import addx_pkg::*;
#(
    parameter  int NREGS  = 8,
    parameter  int ADDR_W = 16,
    localparam int IDX_W  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_size,
    input  logic [1:0]        src_mode,
    input  logic [1:0]        dst_mode,
    input  logic [IDX_W:0]    src_sel,
    input  logic [IDX_W:0]    dst_sel,
    input  logic [31:0]       imm,
    output logic              busy,
    output logic              done,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              reg_load,
    input  logic [IDX_W-1:0]  reg_load_idx,
    input  logic [31:0]       reg_load_data,
    input  logic              ccr_load,
    input  logic [4:0]        ccr_in,
    input  logic [IDX_W-1:0]  dbg_sel,
    output logic [31:0]       dbg_data,
    output logic              flag_h,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    xstate_e                 state_q, state_d;
    logic [1:0]              sz_q, sm_q, dm_q, cnt_q;
    logic [IDX_W:0]          ss_q, ds_q;
    logic [31:0]             imm_q, src_q, dst_q, res_q;
    flags_t                  flags_q, alu_fl;
    logic [NREGS-1:0][31:0]  rf_regs;
    logic [IDX_W-1:0]        sidx, didx;
    logic [31:0]             sreg, dreg, alu_a, alu_b, alu_sum, res_sh;
    logic                    src_mem, dst_mem, src_pd, dst_pd, at_last;
    logic [1:0]              last, wr_sh;
    logic                    rf_we;
    logic [IDX_W-1:0]        rf_idx;
    logic [3:0]              rf_be;
    logic [31:0]             rf_wd;
    xstate_e                 after_wb;

    assign sidx    = ss_q[IDX_W-1:0];
    assign didx    = ds_q[IDX_W-1:0];
    assign sreg    = rf_regs[sidx];
    assign dreg    = rf_regs[didx];
    assign src_mem = sm_q[1];
    assign dst_mem = dm_q[1];
    assign src_pd  = (sm_q == AM_PDEC);
    assign dst_pd  = (dm_q == AM_PDEC);
    assign last    = last_byte(sz_q);
    assign at_last = (cnt_q == last);
    assign wr_sh   = last - cnt_q;
    assign res_sh  = res_q >> {wr_sh, 3'b000};

    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_FIN);
    assign dbg_data = rf_regs[dbg_sel];
    assign {flag_h, flag_n, flag_z, flag_v, flag_c} = flags_q;

    addx_regfile #(.NREGS(NREGS)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rf_we),
        .wr_idx (rf_idx),
        .wr_be  (rf_be),
        .wr_data(rf_wd),
        .regs_o (rf_regs)
    );

    // Choose the adder operands from the latched addressing modes.
    always_comb begin
        alu_a = dst_mem ? dst_q : view_get(dreg, ds_q[IDX_W], sz_q);
        case (sm_q)
            AM_IMM:  alu_b = imm_q & size_mask(sz_q);
            AM_REG:  alu_b = view_get(sreg, ss_q[IDX_W], sz_q);
            default: alu_b = src_q;
        endcase
    end

    addx_alu u_alu (
        .a   (alu_a),
        .b   (alu_b),
        .cin (flags_q.c),
        .sz  (sz_q),
        .z_in(flags_q.z),
        .sum (alu_sum),
        .fl  (alu_fl)
    );

    // Pick the state that follows the writeback: post-decrements, then finish.
    always_comb begin
        if (src_pd)      after_wb = ST_USRC;
        else if (dst_pd) after_wb = ST_UDST;
        else             after_wb = ST_FIN;
    end

    // Next-state sequencing of fetch, add, writeback and address update.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) begin
                if (src_mode[1])      state_d = ST_SRD;
                else if (dst_mode[1]) state_d = ST_DRD;
                else                  state_d = ST_EXEC;
            end
            ST_SRD:  state_d = ST_SCAP;
            ST_SCAP: state_d = at_last ? (dst_mem ? ST_DRD : ST_EXEC) : ST_SRD;
            ST_DRD:  state_d = ST_DCAP;
            ST_DCAP: state_d = at_last ? ST_EXEC : ST_DRD;
            ST_EXEC: state_d = dst_mem ? ST_WR : after_wb;
            ST_WR:   state_d = at_last ? after_wb : ST_WR;
            ST_USRC: state_d = dst_pd ? ST_UDST : ST_FIN;
            ST_UDST: state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Drive the byte-wide memory port from the current state and byte count.
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = res_sh[7:0];
        case (state_q)
            ST_SRD: begin mem_rd = 1'b1; mem_addr = sreg[ADDR_W-1:0] + ADDR_W'(cnt_q); end
            ST_DRD: begin mem_rd = 1'b1; mem_addr = dreg[ADDR_W-1:0] + ADDR_W'(cnt_q); end
            ST_WR:  begin mem_wr = 1'b1; mem_addr = dreg[ADDR_W-1:0] + ADDR_W'(cnt_q); end
            default: ;
        endcase
    end

    // Arbitrate the single register write port between preload, result and steps.
    always_comb begin
        rf_we  = 1'b0;
        rf_idx = reg_load_idx;
        rf_be  = 4'b1111;
        rf_wd  = reg_load_data;
        case (state_q)
            ST_IDLE: rf_we = reg_load;
            ST_EXEC: if (!dst_mem) begin
                rf_we  = 1'b1;
                rf_idx = didx;
                rf_be  = view_be(ds_q[IDX_W], sz_q);
                rf_wd  = view_put(alu_sum, ds_q[IDX_W], sz_q);
            end
            ST_USRC: begin rf_we = 1'b1; rf_idx = sidx; rf_wd = sreg - step_of(sz_q); end
            ST_UDST: begin rf_we = 1'b1; rf_idx = didx; rf_wd = dreg - step_of(sz_q); end
            default: ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Condition flags: preload while idle, update at the add.
    always_ff @(posedge clk) begin
        if (!rst_n)                               flags_q <= '0;
        else if (state_q == ST_IDLE && ccr_load)  flags_q <= flags_t'(ccr_in);
        else if (state_q == ST_EXEC)              flags_q <= alu_fl;
    end

    // Latched operation, byte counter and operand/result holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sz_q <= '0; sm_q <= '0; dm_q <= '0; ss_q <= '0; ds_q <= '0;
            imm_q <= '0; cnt_q <= '0; src_q <= '0; dst_q <= '0; res_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    sz_q  <= op_size;  sm_q <= src_mode; dm_q <= dst_mode;
                    ss_q  <= src_sel;  ds_q <= dst_sel;  imm_q <= imm;
                    cnt_q <= '0;       src_q <= '0;      dst_q <= '0;
                end
                ST_SCAP: begin
                    src_q <= {src_q[23:0], mem_rdata};
                    cnt_q <= at_last ? 2'd0 : cnt_q + 2'd1;
                end
                ST_DCAP: begin
                    dst_q <= {dst_q[23:0], mem_rdata};
                    cnt_q <= at_last ? 2'd0 : cnt_q + 2'd1;
                end
                ST_EXEC: begin
                    res_q <= alu_sum;
                    cnt_q <= '0;
                end
                ST_WR:   cnt_q <= at_last ? 2'd0 : cnt_q + 2'd1;
                default: ;
            endcase
        end
    end

    // R10: completion is a single-cycle pulse.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

    // R10: the latched operation cannot change while the unit is busy.
    a_r10_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(imm_q) && $stable(ss_q) && $stable(ds_q) && $stable(sz_q)));

    // R6: the memory port never reads and writes in the same cycle.
    a_r6_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));

    // R5: an add never raises Z.
    a_r5_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC) |=> (!flag_z || $past(flag_z)));

    // R7: a source post-decrement lowers the address register by the operand size.
    a_r7_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_USRC) |=> (rf_regs[sidx] == $past(rf_regs[sidx] - step_of(sz_q))));
endmodule

// File: tb/addx_unit_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes expected results with its own model and
// queues them; the monitor pops an item at each completion and compares.
module addx_unit_tb;
    localparam int NREGS  = 8;
    localparam int ADDR_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_size = '0, src_mode = '0, dst_mode = '0;
    logic [3:0]  src_sel = '0, dst_sel = '0;
    logic [31:0] imm = '0;
    logic        busy, done, mem_rd, mem_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        reg_load = 1'b0;
    logic [2:0]  reg_load_idx = '0;
    logic [31:0] reg_load_data = '0;
    logic        ccr_load = 1'b0;
    logic [4:0]  ccr_in = '0;
    logic [2:0]  dbg_sel = '0;
    logic [31:0] dbg_data;
    logic        flag_h, flag_n, flag_z, flag_v, flag_c;

    addx_unit #(.NREGS(NREGS), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_size(op_size),
        .src_mode(src_mode), .dst_mode(dst_mode), .src_sel(src_sel), .dst_sel(dst_sel),
        .imm(imm), .busy(busy), .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .reg_load(reg_load), .reg_load_idx(reg_load_idx), .reg_load_data(reg_load_data),
        .ccr_load(ccr_load), .ccr_in(ccr_in), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
        .flag_h(flag_h), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    always #5 clk = ~clk;

    // Memory responder (DUT side) and the model's own copy.
    logic [7:0] mem   [256];
    logic [7:0] m_mem [256];
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    // Model state.
    logic [31:0] m_reg [8];
    logic [4:0]  m_fl;  // {H,N,Z,V,C}

    typedef struct {
        logic [4:0]       fl;
        logic [7:0][31:0] regs;
        string            rtag;
        string            ftag;
    } exp_t;
    exp_t exp_q[$];

    int drv_checks = 0, drv_fails = 0;
    int mon_checks = 0, mon_fails = 0;
    int wd_fails = 0;
    int mon_count = 0;
    int ops_sent = 0;
    logic [7:0][31:0] cur_regs;
    string cur_rtag;
    bit finished = 1'b0;

    function automatic logic [31:0] m_get(input logic [31:0] r, input logic hi, input int w);
        if (w == 8)  return hi ? {24'd0, r[15:8]} : {24'd0, r[7:0]};
        if (w == 16) return hi ? {16'd0, r[31:16]} : {16'd0, r[15:0]};
        return r;
    endfunction

    function automatic logic [31:0] m_put(input logic [31:0] r, input logic [31:0] v,
                                          input logic hi, input int w);
        logic [31:0] o = r;
        if (w == 8) begin
            if (hi) o[15:8] = v[7:0]; else o[7:0] = v[7:0];
        end else if (w == 16) begin
            if (hi) o[31:16] = v[15:0]; else o[15:0] = v[15:0];
        end else o = v;
        return o;
    endfunction

    function automatic logic [31:0] m_rd(input logic [7:0] a, input int nb);
        logic [31:0] v = '0;
        for (int k = 0; k < nb; k++) v = (v << 8) | {24'd0, m_mem[8'(a + 8'(k))]};
        return v;
    endfunction

    task automatic drv_chk(input string req, input string what, input logic [31:0] act,
                           input logic [31:0] exp);
        drv_checks++;
        if (act !== exp) begin
            drv_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic mon_chk(input string req, input string what, input logic [31:0] act,
                           input logic [31:0] exp);
        mon_checks++;
        if (act !== exp) begin
            mon_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Sweep every register through the debug port against an expected set.
    task automatic sweep_regs(input string req, input logic [7:0][31:0] exp);
        for (int i = 0; i < 8; i++) begin
            dbg_sel = 3'(i);
            #1;
            drv_chk(req, $sformatf("reg%0d", i), dbg_data, exp[i]);
        end
    endtask

    task automatic load_reg(input int idx, input logic [31:0] v);
        @(negedge clk);
        reg_load = 1'b1; reg_load_idx = 3'(idx); reg_load_data = v;
        @(negedge clk);
        reg_load = 1'b0;
        m_reg[idx] = v;
    endtask

    task automatic load_ccr(input logic [4:0] v);
        @(negedge clk);
        ccr_load = 1'b1; ccr_in = v;
        @(negedge clk);
        ccr_load = 1'b0;
        m_fl = v;
    endtask

    // Driver: model the operation, queue the expectation, then issue it.
    task automatic run_op(input logic [1:0] sz, input logic [1:0] sm, input logic [1:0] dm,
                          input logic [3:0] ss, input logic [3:0] ds, input logic [31:0] im,
                          input string rtag, input string ftag, input bit poke);
        int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        int nb = w / 8;
        logic [63:0] mask = (64'd1 << w) - 64'd1;
        logic [63:0] hmask = (64'd1 << (w - 4)) - 64'd1;
        logic [63:0] a, b, s, hs;
        logic [31:0] res;
        logic c, h, n, v, z;
        exp_t it;
        if (sm == 2'd0)      b = {32'd0, im} & mask;
        else if (sm == 2'd1) b = {32'd0, m_get(m_reg[ss[2:0]], ss[3], w)};
        else                 b = {32'd0, m_rd(m_reg[ss[2:0]][7:0], nb)};
        if (dm[1]) a = {32'd0, m_rd(m_reg[ds[2:0]][7:0], nb)};
        else       a = {32'd0, m_get(m_reg[ds[2:0]], ds[3], w)};
        s   = a + b + {63'd0, m_fl[0]};
        hs  = (a & hmask) + (b & hmask) + {63'd0, m_fl[0]};
        res = 32'(s & mask);
        c   = s[w];
        h   = hs[w-4];
        n   = res[w-1];
        v   = (a[w-1] == b[w-1]) && (res[w-1] != a[w-1]);
        z   = m_fl[2] && (res == 32'd0);
        m_fl = {h, n, z, v, c};
        if (dm[1]) begin
            for (int k = 0; k < nb; k++)
                m_mem[8'(m_reg[ds[2:0]][7:0] + 8'(k))] = 8'(res >> (8 * (nb - 1 - k)));
        end else m_reg[ds[2:0]] = m_put(m_reg[ds[2:0]], res, ds[3], w);
        if (sm == 2'd3) m_reg[ss[2:0]] = m_reg[ss[2:0]] - 32'(nb);
        if (dm == 2'd3) m_reg[ds[2:0]] = m_reg[ds[2:0]] - 32'(nb);
        it.fl = m_fl;
        for (int i = 0; i < 8; i++) it.regs[i] = m_reg[i];
        it.rtag = rtag;
        it.ftag = ftag;
        exp_q.push_back(it);
        ops_sent++;

        @(negedge clk);
        op_size = sz; src_mode = sm; dst_mode = dm; src_sel = ss; dst_sel = ds; imm = im;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_size = 2'd0; src_mode = 2'd0; dst_mode = 2'd1; src_sel = 4'd7; dst_sel = 4'd7;
        imm = 32'hFFFF_FFFF;
        if (poke) begin
            // R10: a second start in the middle of the operation must be ignored.
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (mon_count < ops_sent) @(negedge clk);
        sweep_regs(cur_rtag, cur_regs);
    endtask

    // Monitor: pop at each completion, compare flags, memory and the pulse width.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                mon_chk("R10", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t it;
                int bad;
                it = exp_q.pop_front();
                mon_chk(it.ftag, "flags HNZVC",
                        {27'd0, flag_h, flag_n, flag_z, flag_v, flag_c}, {27'd0, it.fl});
                bad = 0;
                for (int k = 0; k < 256; k++) if (mem[k] !== m_mem[k]) bad++;
                mon_chk("R6", "memory bytes differing", 32'(bad), 32'd0);
                cur_regs = it.regs;
                cur_rtag = it.rtag;
            end
            @(negedge clk);
            mon_chk("R10", "done after one cycle", {31'd0, done}, 32'd0);
            mon_count++;
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            wd_fails = 1;
            $display("FAIL watchdog expired actual=%0d expected=%0d", ops_sent, mon_count);
            $display("TB_RESULT checks=%0d failures=%0d",
                     drv_checks + mon_checks + 1, drv_fails + mon_fails + wd_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0][31:0] zeros;
        for (int k = 0; k < 256; k++) begin
            mem[k]   = 8'(k * 37 + 11);
            m_mem[k] = 8'(k * 37 + 11);
        end
        for (int i = 0; i < 8; i++) begin m_reg[i] = '0; zeros[i] = '0; end
        m_fl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state of flags and registers.
        drv_chk("R11", "flags after reset",
                {27'd0, flag_h, flag_n, flag_z, flag_v, flag_c}, 32'd0);
        drv_chk("R10", "busy after reset", {31'd0, busy}, 32'd0);
        sweep_regs("R11", zeros);

        for (int i = 0; i < 8; i++) load_reg(i, 32'hA5A5_A5A5);

        // R1: byte immediate to low byte, carry clear.
        run_op(2'd0, 2'd0, 2'd1, 4'h0, 4'h0, 32'h0000_0005, "R1", "R4", 1'b0);
        // R4: byte giving zero with carry and half carry out.
        run_op(2'd0, 2'd0, 2'd1, 4'h0, 4'h1, 32'h0000_005B, "R9", "R4", 1'b0);
        // R2: register byte into the high byte view, with carry in.
        run_op(2'd0, 2'd1, 2'd1, 4'h0, 4'hA, 32'h0, "R2", "R4", 1'b0);
        // R3: word immediate into the upper word view.
        run_op(2'd1, 2'd0, 2'd1, 4'h0, 4'hB, 32'h0000_0505, "R3", "R4", 1'b0);
        // R3: long register to register.
        run_op(2'd2, 2'd1, 2'd1, 4'h3, 4'h4, 32'h0, "R3", "R4", 1'b0);
        // R4: signed overflow at byte size.
        load_reg(5, 32'h0000_007F);
        load_ccr(5'b00000);
        run_op(2'd0, 2'd0, 2'd1, 4'h0, 4'h5, 32'h0000_0001, "R1", "R4", 1'b0);
        // R5: zero result keeps Z set, then a nonzero result clears it.
        load_reg(6, 32'h0000_0001);
        load_ccr(5'b00100);
        run_op(2'd0, 2'd0, 2'd1, 4'h0, 4'h6, 32'h0000_00FF, "R5", "R5", 1'b0);
        run_op(2'd1, 2'd0, 2'd1, 4'h0, 4'h6, 32'h0000_0000, "R5", "R5", 1'b0);
        // R6: word from indirect memory to register; address register unchanged.
        load_reg(2, 32'h0000_0040);
        run_op(2'd1, 2'd2, 2'd1, 4'h2, 4'h7, 32'h0, "R6", "R4", 1'b0);
        // R7: long immediate into post-decrement memory destination.
        load_reg(4, 32'h0000_0080);
        run_op(2'd2, 2'd0, 2'd3, 4'h0, 4'h4, 32'h0005_0505, "R7", "R4", 1'b0);
        // R8: word memory to memory with both registers post-decrementing.
        load_reg(5, 32'h0000_0020);
        load_reg(6, 32'h0000_0060);
        run_op(2'd1, 2'd3, 2'd3, 4'h5, 4'h6, 32'h0, "R8", "R4", 1'b0);
        // R7: byte post-decrement source into high byte, destination mode 0 (register).
        run_op(2'd0, 2'd3, 2'd0, 4'h5, 4'h9, 32'h0, "R7", "R1", 1'b0);
        // R10: long memory to memory with a stray start in the middle.
        load_reg(3, 32'h0000_0090);
        run_op(2'd2, 2'd2, 2'd2, 4'h2, 4'h3, 32'h0, "R10", "R4", 1'b1);
        repeat (4) @(negedge clk);
        drv_chk("R10", "idle after stray start", {31'd0, busy}, 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d",
                 drv_checks + mon_checks, drv_fails + mon_fails);
        $finish;
    end
endmodule